// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the programmable feedback divider that follows a dual-modulus prescaler in a frequency synthesizer loop. It is clocked by the prescaler output. In every full division cycle it counts a main value B of prescaler periods. For the first A of those periods it asks the prescaler to divide by P+1, and for the rest it asks for P. The VCO is therefore divided by P·B + A overall, and the block emits one pulse per full cycle towards the phase detector.

The swallow value A and the main value B come from configuration latches outside the block. They are copied into the counters only when a full cycle ends, so a rewrite part-way through a cycle never produces a short or stretched cycle. Settings that are not allowed are clamped, and a flag reports them. A hold input (counter reset or powerdown) keeps both counters at their load values. Once hold is released, the divider starts a fresh full cycle in step with the reference side. A width parameter selects how many swallow bits are used, so the same RTL serves a 7-bit swallow channel and a 4-bit one.

Top module: `psw_divider`

## Requirements
- R1: Consecutive rising edges of `div_pulse` are exactly B' prescaler periods apart, and `mod_hi` is high in exactly A' of those periods. B' and A' are the clamped settings. The VCO division per cycle is therefore P·B' + A'.
- R2: Within a full cycle, `mod_hi` is high from the cycle's first prescaler period onward and, once low, stays low until the cycle ends.
- R3: `div_pulse` is high for exactly one prescaler period per full cycle, in the first period of that cycle.
- R4: With A = 0, `mod_hi` stays low for the whole cycle. With A = B, it stays high for the whole cycle.
- R5: A change of `a_cfg`/`b_cfg` during a cycle leaves that cycle's length and swallow count unchanged. The new values govern the following cycle.
- R6: A `b_cfg` below 3 is used as B' = 3, and `cfg_err` is 1 while that input is present.
- R7: An effective swallow value above B' is used as A' = B', and `cfg_err` is 1. For a legal setting, `cfg_err` is 0.
- R8: With parameter `A_USED_W` below `A_W`, the `a_cfg` bits at positions `A_USED_W` and above are ignored. For example, with 4 bits used, `a_cfg` = 83 acts as A = 3.
- R9: While `hold` is 1, `div_pulse` stays 0. The first `div_pulse` after `hold` falls comes exactly B' periods later, and `mod_hi` is high in A' of those periods.
- R10: While `rst_n` is low, `div_pulse` and `mod_hi` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hold | input | 1 | Counter reset / powerdown: keeps counters at load values |
| a_cfg | input | A_W | Latched swallow value A |
| b_cfg | input | B_W | Latched main value B |
| mod_hi | output | 1 | 1 selects prescaler modulus P+1, 0 selects P |
| div_pulse | output | 1 | One-period pulse at each full-cycle boundary |
| cfg_err | output | 1 | Current setting is illegal and has been clamped |

## Verification
The bench builds two instances on one clock. One uses the default 7-bit swallow field with an 11-bit main field. The other uses only 4 swallow bits, which brings the ignored upper bits within reach: the same `a_cfg` is legal on one instance and clamped on the other. A behavioural prescaler of P = 8 adds P or P+1 VCO periods per prescaler period according to `mod_hi`, so the bench can compare the division with 8·B + A. The 11-bit default lets the bench run the largest setting, B = 2047 with A = 127.

// File: rtl/psw_pkg.sv
package psw_pkg;
  // Smallest main count the divider accepts
  localparam int unsigned MIN_MAIN = 3;
  // Synchronizer depth for reset release
  localparam int unsigned RST_STAGES = 2;
endpackage

// File: rtl/psw_rst_sync.sv
module psw_rst_sync
  import psw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [RST_STAGES-1:0] stage_q;
  logic [RST_STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[RST_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_q_n = stage_q[RST_STAGES-1];
endmodule

// File: rtl/psw_cfg_clamp.sv
module psw_cfg_clamp
  import psw_pkg::*;
#(
  parameter int unsigned A_W      = 7,
  parameter int unsigned B_W      = 11,
  parameter int unsigned A_USED_W = 7
) (
  input  logic [A_W-1:0] a_raw,
  input  logic [B_W-1:0] b_raw,
  output logic [A_W-1:0] a_eff,
  output logic [B_W-1:0] b_eff,
  output logic           err
);
  localparam int unsigned CW = (A_W > B_W) ? A_W : B_W;

  logic [A_W-1:0] a_msk;
  logic           b_low;
  logic           a_big;

  // Keep only the swallow bits this channel uses
  generate
    if (A_USED_W < A_W) begin : g_mask
      assign a_msk = {{(A_W-A_USED_W){1'b0}}, a_raw[A_USED_W-1:0]};
    end else begin : g_full
      assign a_msk = a_raw;
    end
  endgenerate

  always_comb begin
    b_low = (b_raw < B_W'(MIN_MAIN));
    b_eff = b_low ? B_W'(MIN_MAIN) : b_raw;
    a_big = (CW'(a_msk) > CW'(b_eff));
    a_eff = a_big ? A_W'(b_eff) : a_msk;
    err   = b_low | a_big;
  end
endmodule

// File: rtl/psw_count.sv
module psw_count
  import psw_pkg::*;
#(
  parameter int unsigned A_W = 7,
  parameter int unsigned B_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic [A_W-1:0] a_load,
  input  logic [B_W-1:0] b_load,
  output logic           mod_hi,
  output logic           div_pulse
);
  localparam int unsigned CW = (A_W > B_W) ? A_W : B_W;

  logic [B_W-1:0] b_rem_q, b_rem_d;
  logic [A_W-1:0] a_rem_q, a_rem_d;
  logic           pulse_q, pulse_d;
  logic           last;
  logic           ld;
  logic           dec_en;

  // Next-state logic
  always_comb begin
    last    = (b_rem_q <= B_W'(1));
    ld      = hold | last;
    dec_en  = ~ld;
    b_rem_d = b_rem_q;
    a_rem_d = a_rem_q;
    if (ld) begin
      b_rem_d = b_load;
      a_rem_d = a_load;
    end else if (dec_en) begin
      b_rem_d = b_rem_q - 1'b1;
      if (a_rem_q != '0) a_rem_d = a_rem_q - 1'b1;
    end
    pulse_d = last & ~hold;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_rem_q <= '0;
      a_rem_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      b_rem_q <= b_rem_d;
      a_rem_q <= a_rem_d;
      pulse_q <= pulse_d;
    end
  end

  assign mod_hi    = (a_rem_q != '0);
  assign div_pulse = pulse_q;

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);
  // R2
  swallow_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rem_q == '0 && !ld) |=> (a_rem_q == '0));
  // R7
  swallow_le_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(a_rem_q) <= CW'(b_rem_q));
  // R9
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !div_pulse);
  // R6
  main_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_rem_q != '0) |=> (b_rem_q != '0));
endmodule

// File: rtl/psw_divider.sv
module psw_divider
  import psw_pkg::*;
#(
  parameter int unsigned A_W      = 7,
  parameter int unsigned B_W      = 11,
  parameter int unsigned A_USED_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic [A_W-1:0] a_cfg,
  input  logic [B_W-1:0] b_cfg,
  output logic           mod_hi,
  output logic           div_pulse,
  output logic           cfg_err
);
  logic           rst_q_n;
  logic [A_W-1:0] a_eff;
  logic [B_W-1:0] b_eff;

  psw_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  psw_cfg_clamp #(.A_W(A_W), .B_W(B_W), .A_USED_W(A_USED_W)) u_clamp (
    .a_raw (a_cfg),
    .b_raw (b_cfg),
    .a_eff (a_eff),
    .b_eff (b_eff),
    .err   (cfg_err)
  );

  psw_count #(.A_W(A_W), .B_W(B_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .hold      (hold),
    .a_load    (a_eff),
    .b_load    (b_eff),
    .mod_hi    (mod_hi),
    .div_pulse (div_pulse)
  );

  // R6
  load_min_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    b_eff >= B_W'(MIN_MAIN));
endmodule

// File: tb/psw_divider_tb.sv
`timescale 1ns/1ps
module psw_divider_tb;
  localparam int P = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        hold = 1'b0;
  logic [6:0]  a_cfg = 7'd0;
  logic [10:0] b_cfg = 11'd5;
  logic        mod_hi, div_pulse, cfg_err;
  logic        mod_hi_if, div_pulse_if, cfg_err_if;
  int          tests = 0;
  int          fails = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  psw_divider u_dut (
    .clk(clk), .rst_n(rst_n), .hold(hold), .a_cfg(a_cfg), .b_cfg(b_cfg),
    .mod_hi(mod_hi), .div_pulse(div_pulse), .cfg_err(cfg_err));

  psw_divider #(.A_USED_W(4)) u_dut_if (
    .clk(clk), .rst_n(rst_n), .hold(hold), .a_cfg(a_cfg), .b_cfg(b_cfg),
    .mod_hi(mod_hi_if), .div_pulse(div_pulse_if), .cfg_err(cfg_err_if));

  function automatic bit pul(bit s);
    return s ? div_pulse_if : div_pulse;
  endfunction
  function automatic bit md(bit s);
    return s ? mod_hi_if : mod_hi;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_pulse(bit s);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pul(s) && n < 5000);
  endtask

  // Counts from the current period up to (not including) the next pulse
  task automatic measure(bit s, output int cyc, output int hi, output int vco,
                         output bit order_ok, output bit wid_ok);
    bit seen_low = 0;
    cyc = 0; hi = 0; vco = 0; order_ok = 1; wid_ok = 1;
    forever begin
      if (md(s)) begin
        hi++; vco += P + 1;
        if (seen_low) order_ok = 0;
      end else begin
        seen_low = 1; vco += P;
      end
      cyc++;
      @(negedge clk);
      if (pul(s)) begin
        if (cyc == 1) wid_ok = 0;
        break;
      end
      if (cyc > 5000) break;
    end
  endtask

  task automatic check_period(bit s, string req, int ea, int eb);
    int cyc, hi, vco;
    bit ord, wid;
    measure(s, cyc, hi, vco, ord, wid);
    check(cyc == eb, req, "period", cyc, eb);
    check(hi == ea, req, "P+1 periods", hi, ea);
    check(vco == P*eb + ea, req, "VCO division", vco, P*eb + ea);
    check(ord, "R2", "modulus order", ord, 1);
    check(wid, "R3", "pulse width", wid, 1);
  endtask

  task automatic run_case(bit s, string req, int a, int b, int ea, int eb);
    a_cfg = 7'(a);
    b_cfg = 11'(b);
    wait_pulse(s);
    check_period(s, req, ea, eb);
  endtask

  task automatic t_reset;
    #20;
    check(div_pulse == 0, "R10", "pulse in reset", div_pulse, 0);
    check(mod_hi == 0, "R10", "mod_hi in reset", mod_hi, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_basic;
    run_case(0, "R1", 5, 20, 5, 20);
    run_case(0, "R1", 3, 7, 3, 7);
    run_case(0, "R1", 100, 300, 100, 300);
    run_case(0, "R1", 127, 2047, 127, 2047);
  endtask

  task automatic t_ends;
    run_case(0, "R4", 0, 9, 0, 9);
    run_case(0, "R4", 12, 12, 12, 12);
  endtask

  task automatic t_reconfig;
    run_case(0, "R5", 2, 10, 2, 10);
    // now in the first period of a cycle loaded with A=2, B=10
    a_cfg = 7'd4;
    b_cfg = 11'd6;
    check_period(0, "R5", 2, 10);
    check_period(0, "R5", 4, 6);
  endtask

  task automatic t_clamp;
    a_cfg = 7'd0; b_cfg = 11'd2; #1;
    check(cfg_err == 1, "R6", "err for B=2", cfg_err, 1);
    run_case(0, "R6", 0, 2, 0, 3);
    run_case(0, "R6", 1, 1, 1, 3);
    a_cfg = 7'd9; b_cfg = 11'd5; #1;
    check(cfg_err == 1, "R7", "err for A>B", cfg_err, 1);
    run_case(0, "R7", 9, 5, 5, 5);
    a_cfg = 7'd5; b_cfg = 11'd9; #1;
    check(cfg_err == 0, "R7", "err for legal", cfg_err, 0);
    run_case(0, "R7", 5, 9, 5, 9);
  endtask

  task automatic t_if_mask;
    a_cfg = 7'd83; b_cfg = 11'd10; #1;
    check(cfg_err_if == 0, "R8", "4-bit err", cfg_err_if, 0);
    check(cfg_err == 1, "R8", "7-bit err", cfg_err, 1);
    run_case(1, "R8", 83, 10, 3, 10);
    run_case(1, "R8", 16, 4, 0, 4);
  endtask

  task automatic t_hold;
    int cyc, hi, vco;
    bit ord, wid;
    a_cfg = 7'd3; b_cfg = 11'd8;
    wait_pulse(0);
    @(negedge clk);
    hold = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(div_pulse == 0 && div_pulse_if == 0, "R9", "pulse during hold",
            div_pulse | div_pulse_if, 0);
    end
    hold = 1'b0;
    measure(0, cyc, hi, vco, ord, wid);
    check(cyc == 8, "R9", "periods to first pulse", cyc, 8);
    check(hi == 3, "R9", "P+1 periods after release", hi, 3);
    check(vco == P*8 + 3, "R9", "VCO count after release", vco, P*8 + 3);
  endtask

  initial begin
    #2 rst_n = 1'b0;
    t_reset();
    t_basic();
    t_ends();
    t_reconfig();
    t_clamp();
    t_if_mask();
    t_hold();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule